// File: doc/BRIEF.md
# Flash Mailbox Command Target

This block is the device end of a register-mapped mailbox through which a management host drives a flash image. A capability base sets where a small register window sits in the register space. The window holds sixteen data words, one command word and one status word. The host starts an operation by writing a command word with its request bit set. The block then decodes the operation and runs it against an on-chip flash model. The model has an image area and a separate, smaller header area.

The supported operations are block read, block write, image authentication and power-cycle. When an operation ends, the block posts a status word that carries a response flag, the code of the command that produced it and a result code. It then clears the request bit, and the host treats that clear as completion. The request bit is therefore a busy flag that hardware owns. While it is set, the command word cannot be overwritten.

Top module: `fmb_mailbox`

## Requirements
- R1: After reset, every register in the window reads zero and `reset_request` is low.
- R2: Register offsets are relative to `CAP_BASE`: offset k+1 (k = 0..15) is data word k, offset 17 is the command word and offset 18 is the status word. Any other offset reads zero, and a bus write to the status word has no effect on it.
- R3: Command word fields are: bits 31:28 operation code, bits 27:24 count, bits 23:2 dword address, bit 1 header select and bit 0 request. For a block write (code 0x0), count+1 words are copied from data words 0..count into consecutive flash words, starting at the dword address.
- R4: For a block read (code 0x2), a count of 0 moves 16 words and any other count moves that many. The words are copied from consecutive flash words into data words 0..n-1.
- R5: When an operation ends, the request bit reads 0 and the other command bits keep their values. The status word reads bit 29 = 1, bits 7:4 = the operation code and bits 3:0 = the result (0 completed, 1 authentication error, 2 access error). All other status bits read 0.
- R6: With header select set, a read or a write targets the header area (`HDR_WORDS` words) and leaves the image area unchanged.
- R7: An access that would touch a word at or beyond the end of its area, or an operation code outside {0x0, 0x1, 0x2, 0x4}, completes with result 2 and changes no flash word. An access ending exactly at the last word succeeds.
- R8: Authentication (code 0x1) returns result 0 when image word `MARKER_ADDR` equals `MARKER_VALUE`, and result 1 otherwise.
- R9: Power-cycle (code 0x4) completes with result 0 and drives `reset_request` high for exactly one cycle. No other operation drives it.
- R10: A bus write to the command word while the request bit is set leaves the command word unchanged and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| reset_request | output | 1 | One-cycle pulse requesting a power cycle |

## Verification
The bench builds the block with `CAP_BASE` = 0x10, a 32-word image area, an 8-word header area and the marker at image word 5. These small sizes let one run sweep every transfer length from 1 to 16, in both directions, against a bench model of both areas. At the same sizes the end-of-area boundary can be reached from both sides, both exactly and by overrun. They also put the marker inside data that the sweep writes, so authentication is checked both with and without a match.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
   localparam int WIN_WORDS = 16;
   localparam int OFF_CMD   = 17;
   localparam int OFF_STAT  = 18;
   localparam int RESP_BIT  = 29;

   localparam logic [3:0] OP_WRITE = 4'h0;
   localparam logic [3:0] OP_AUTH  = 4'h1;
   localparam logic [3:0] OP_READ  = 4'h2;
   localparam logic [3:0] OP_PWR   = 4'h4;

   localparam logic [3:0] RES_OK     = 4'd0;
   localparam logic [3:0] RES_AUTH   = 4'd1;
   localparam logic [3:0] RES_ACCESS = 4'd2;

   typedef struct packed {
      logic [3:0]  code;
      logic [3:0]  cnt;
      logic [21:0] dwaddr;
      logic        hdr;
      logic        req;
   } cmd_t;

   typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_POST} eng_st_e;
endpackage

// File: rtl/fmb_cmd_decode.sv
module fmb_cmd_decode
   import fmb_pkg::*;
#(
   parameter int IMG_WORDS = 256,
   parameter int HDR_WORDS = 64
) (
   input  logic [3:0]  code,
   input  logic [3:0]  cnt,
   input  logic [21:0] dwaddr,
   input  logic        hdr,
   output logic [4:0]  nwords,
   output logic        in_range
);
   localparam int LIMW = 24;

   logic [LIMW-1:0] end_addr;
   logic [LIMW-1:0] limit;

   always_comb begin
      // read: zero means a full window; write: field is count minus one
      if (code == OP_READ) nwords = (cnt == 4'd0) ? 5'd16 : {1'b0, cnt};
      else                 nwords = {1'b0, cnt} + 5'd1;
      end_addr = {2'b00, dwaddr} + {{(LIMW-5){1'b0}}, nwords};
      limit    = hdr ? LIMW'(HDR_WORDS) : LIMW'(IMG_WORDS);
      in_range = (end_addr <= limit);
   end
endmodule

// File: rtl/fmb_store.sv
module fmb_store #(
   parameter int DEPTH = 256,
   parameter int DW    = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [DW-1:0]            wdata,
   output logic [DW-1:0]            rdata
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fmb_store: DEPTH must be at least 2");
      end
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign rdata = mem[addr];
      end else begin : g_guard
         assign rdata = (int'(addr) < DEPTH) ? mem[addr] : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end
endmodule

// File: rtl/fmb_engine.sv
module fmb_engine
   import fmb_pkg::*;
#(
   parameter int          MAW          = 8,
   parameter int          MARKER_ADDR  = 0,
   parameter logic [31:0] MARKER_VALUE = 32'h5AA5_C33C
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic [3:0]     code,
   input  logic [4:0]     nwords,
   input  logic [MAW-1:0] base,
   input  logic           hdr,
   input  logic           in_range,
   input  logic [31:0]    img_rdata,
   input  logic [31:0]    hdr_rdata,
   output logic [MAW-1:0] mem_addr,
   output logic           img_we,
   output logic           hdr_we,
   output logic [3:0]     win_idx,
   output logic           fill_en,
   output logic [31:0]    fill_data,
   output logic           done,
   output logic [3:0]     done_code,
   output logic [3:0]     done_res
);
   eng_st_e        st_q;
   logic [3:0]     code_q, res_q, idx_q;
   logic [4:0]     n_q;
   logic [MAW-1:0] base_q;
   logic           hdr_q;
   logic           last;

   assign last = ({1'b0, idx_q} == (n_q - 5'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         code_q <= '0;
         res_q  <= '0;
         idx_q  <= '0;
         n_q    <= '0;
         base_q <= '0;
         hdr_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (req) begin
               code_q <= code;
               n_q    <= nwords;
               base_q <= base;
               hdr_q  <= hdr;
               idx_q  <= '0;
               case (code)
                  OP_READ, OP_WRITE: begin
                     if (in_range) st_q <= ST_XFER;
                     else begin
                        res_q <= RES_ACCESS;
                        st_q  <= ST_POST;
                     end
                  end
                  OP_AUTH: begin
                     res_q <= (img_rdata == MARKER_VALUE) ? RES_OK : RES_AUTH;
                     st_q  <= ST_POST;
                  end
                  OP_PWR: begin
                     res_q <= RES_OK;
                     st_q  <= ST_POST;
                  end
                  default: begin
                     res_q <= RES_ACCESS;
                     st_q  <= ST_POST;
                  end
               endcase
            end
            ST_XFER: begin
               if (last) begin
                  res_q <= RES_OK;
                  st_q  <= ST_POST;
               end else begin
                  idx_q <= idx_q + 4'd1;
               end
            end
            ST_POST: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = (st_q == ST_IDLE) ? MAW'(MARKER_ADDR) : (base_q + MAW'(idx_q));
      img_we    = (st_q == ST_XFER) && (code_q == OP_WRITE) && !hdr_q;
      hdr_we    = (st_q == ST_XFER) && (code_q == OP_WRITE) && hdr_q;
      fill_en   = (st_q == ST_XFER) && (code_q == OP_READ);
      fill_data = hdr_q ? hdr_rdata : img_rdata;
      win_idx   = idx_q;
      done      = (st_q == ST_POST);
      done_code = code_q;
      done_res  = res_q;
   end

   assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_XFER) |-> ({1'b0, idx_q} < n_q));
   assert_post_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_POST) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/fmb_mailbox.sv
module fmb_mailbox
   import fmb_pkg::*;
#(
   parameter int          RAW          = 8,
   parameter int          CAP_BASE     = 'h40,
   parameter int          IMG_WORDS    = 256,
   parameter int          HDR_WORDS    = 64,
   parameter int          MARKER_ADDR  = 0,
   parameter logic [31:0] MARKER_VALUE = 32'h5AA5_C33C
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr_en,
   input  logic [RAW-1:0] reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   output logic           reset_request
);
   localparam int MAW = $clog2((IMG_WORDS > HDR_WORDS) ? IMG_WORDS : HDR_WORDS);
   localparam int IAW = $clog2(IMG_WORDS);
   localparam int HAW = $clog2(HDR_WORDS);

   generate
      if (IMG_WORDS < 2 || HDR_WORDS < 2 || IMG_WORDS > (1 << 22) || HDR_WORDS > (1 << 22))
      begin : g_bad_area
         $error("fmb_mailbox: area sizes out of range");
      end
      if (MARKER_ADDR < 0 || MARKER_ADDR >= IMG_WORDS) begin : g_bad_marker
         $error("fmb_mailbox: marker outside image area");
      end
      if (CAP_BASE < 0 || CAP_BASE + OFF_STAT >= (1 << RAW)) begin : g_bad_base
         $error("fmb_mailbox: register window does not fit address space");
      end
   endgenerate

   logic [31:0]    win [WIN_WORDS];
   logic [31:0]    cmd_q, status_q;
   cmd_t           cmd_s;
   logic [RAW-1:0] rel;
   logic           cmd_hit;
   logic [4:0]     nwords;
   logic           in_range;
   logic [MAW-1:0] mem_addr;
   logic           img_we, hdr_we, fill_en, eng_done;
   logic [3:0]     win_idx, done_code, done_res;
   logic [31:0]    fill_data, img_rdata, hdr_rdata, win_word;

   assign cmd_s    = cmd_q;
   assign rel      = reg_addr - RAW'(CAP_BASE);
   assign cmd_hit  = reg_wr_en && (rel == RAW'(OFF_CMD));
   assign win_word = win[win_idx];

   fmb_cmd_decode #(.IMG_WORDS(IMG_WORDS), .HDR_WORDS(HDR_WORDS)) u_dec (
      .code(cmd_s.code), .cnt(cmd_s.cnt), .dwaddr(cmd_s.dwaddr), .hdr(cmd_s.hdr),
      .nwords(nwords), .in_range(in_range)
   );

   fmb_engine #(.MAW(MAW), .MARKER_ADDR(MARKER_ADDR), .MARKER_VALUE(MARKER_VALUE)) u_eng (
      .clk(clk), .rst_n(rst_n), .req(cmd_s.req), .code(cmd_s.code), .nwords(nwords),
      .base(cmd_s.dwaddr[MAW-1:0]), .hdr(cmd_s.hdr), .in_range(in_range),
      .img_rdata(img_rdata), .hdr_rdata(hdr_rdata), .mem_addr(mem_addr),
      .img_we(img_we), .hdr_we(hdr_we), .win_idx(win_idx), .fill_en(fill_en),
      .fill_data(fill_data), .done(eng_done), .done_code(done_code), .done_res(done_res)
   );

   fmb_store #(.DEPTH(IMG_WORDS), .DW(32)) u_img (
      .clk(clk), .we(img_we), .addr(mem_addr[IAW-1:0]), .wdata(win_word), .rdata(img_rdata)
   );

   fmb_store #(.DEPTH(HDR_WORDS), .DW(32)) u_hdr (
      .clk(clk), .we(hdr_we), .addr(mem_addr[HAW-1:0]), .wdata(win_word), .rdata(hdr_rdata)
   );

   // data window: engine fill has priority over a host write to the same word
   generate
      for (genvar k = 0; k < WIN_WORDS; k++) begin : g_win
         always_ff @(posedge clk) begin
            if (!rst_n)                                        win[k] <= '0;
            else if (fill_en && (win_idx == 4'(k)))            win[k] <= fill_data;
            else if (reg_wr_en && (rel == RAW'(k + 1)))        win[k] <= reg_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q         <= '0;
         status_q      <= '0;
         reset_request <= 1'b0;
      end else begin
         reset_request <= eng_done && (done_code == OP_PWR);
         if (eng_done) begin
            cmd_q[0] <= 1'b0;
            status_q <= (32'd1 << RESP_BIT) | {24'd0, done_code, done_res};
         end else if (cmd_hit && !cmd_q[0]) begin
            cmd_q <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < WIN_WORDS; k++) begin
         if (rel == RAW'(k + 1)) reg_rdata = win[k];
      end
      if (rel == RAW'(OFF_CMD))  reg_rdata = cmd_q;
      if (rel == RAW'(OFF_STAT)) reg_rdata = status_q;
   end

   assert_resp_on_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_q[0]) |-> status_q[RESP_BIT]);
   assert_cmd_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[0] && !eng_done) |=> $stable(cmd_q));
   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_request |=> !reset_request);
   assert_pulse_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_request |-> (status_q[7:4] == OP_PWR));
   assert_result_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[3:0] <= RES_ACCESS);
   assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (img_we || hdr_we) |-> cmd_q[0]);
endmodule

// File: tb/tb_fmb_mailbox.sv
module tb_fmb_mailbox;
   localparam int          RAW  = 8;
   localparam int          CAP  = 'h10;
   localparam int          IMG  = 32;
   localparam int          HDR  = 8;
   localparam int          MADR = 5;
   localparam logic [31:0] MVAL = 32'hC0DE_F00D;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr_en = 1'b0;
   logic [RAW-1:0] reg_addr = '0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           reset_request;

   int nchk = 0, nfail = 0, pcnt = 0;
   logic [31:0] img_m [IMG];
   logic [31:0] hdr_m [HDR];

   always #2.5 clk = ~clk;

   fmb_mailbox #(.RAW(RAW), .CAP_BASE(CAP), .IMG_WORDS(IMG), .HDR_WORDS(HDR),
                 .MARKER_ADDR(MADR), .MARKER_VALUE(MVAL)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reset_request(reset_request)
   );

   always @(negedge clk) if (rst_n && reset_request) pcnt++;

   function automatic logic [31:0] pat(int a, int i, int s);
      return (32'h9E37_79B9 * 32'(a + i + 1)) ^ (32'(s) << 20) ^ 32'(i);
   endfunction

   function automatic logic [31:0] stat(logic [3:0] code, logic [3:0] res);
      return 32'h2000_0000 | {24'd0, code, res};
   endfunction

   function automatic logic [31:0] mk(logic [3:0] code, logic [3:0] cnt, int a, logic h);
      return {code, cnt, 22'(a), h, 1'b1};
   endfunction

   task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", rq, got, exp);
      end
   endtask

   task automatic bus_write(input int off, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_addr  = RAW'(CAP + off);
      reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic bus_read(input int off, output logic [31:0] d);
      reg_addr = RAW'(CAP + off);
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] v;
      bit ok = 0;
      for (int i = 0; i < 100 && !ok; i++) begin
         @(negedge clk);
         bus_read(17, v);
         if (!v[0]) ok = 1;
      end
      if (!ok) begin
         nchk++; nfail++;
         $display("FAIL R5: request bit never cleared, got %h expected 0", v[0]);
      end
   endtask

   task automatic issue(input logic [31:0] cmd, input logic [31:0] exp_stat, input string rq);
      logic [31:0] v;
      bus_write(17, cmd);
      wait_done();
      bus_read(18, v);
      check(rq, v, exp_stat);
   endtask

   task automatic do_write(input logic h, input int a, input int n, input int s, input bit ok);
      for (int i = 0; i < n; i++) bus_write(1 + i, pat(a, i, s));
      issue(mk(4'h0, 4'(n - 1), a, h), stat(4'h0, ok ? 4'd0 : 4'd2), ok ? "R3" : "R7");
      if (ok) begin
         for (int i = 0; i < n; i++) begin
            if (h) hdr_m[a + i] = pat(a, i, s);
            else   img_m[a + i] = pat(a, i, s);
         end
      end
   endtask

   task automatic do_read(input logic h, input int a, input int n, input string rq);
      logic [31:0] v;
      issue(mk(4'h2, (n == 16) ? 4'd0 : 4'(n), a, h), stat(4'h2, 4'd0), "R4");
      for (int i = 0; i < n; i++) begin
         bus_read(1 + i, v);
         check(rq, v, h ? hdr_m[a + i] : img_m[a + i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v, c0;
      int p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: whole window and both neighbours read zero after reset
      for (int off = 0; off <= 19; off++) begin
         bus_read(off, v);
         check("R1", v, 32'd0);
      end
      check("R1", 32'(reset_request), 32'd0);

      // fill both areas with known content
      do_write(1'b0, 0, 16, 1, 1);
      do_write(1'b0, 16, 16, 1, 1);
      do_write(1'b1, 0, 8, 2, 1);

      // R2: offsets just outside the window read zero; status ignores writes
      bus_read(0, v);  check("R2", v, 32'd0);
      bus_read(19, v); check("R2", v, 32'd0);
      bus_write(18, 32'hFFFF_FFFF);
      bus_read(18, v); check("R2", v, stat(4'h0, 4'd0));

      // R3 sweep: every write length, positions derived from the length
      for (int n = 1; n <= 16; n++) do_write(1'b0, (n * 7) % (33 - n), n, n + 10, 1);
      // R4 sweep: every read length, count field 0 for sixteen words
      for (int n = 1; n <= 16; n++) do_read(1'b0, (n * 5) % (33 - n), n, "R4");
      do_read(1'b0, 0, 16, "R4");
      do_read(1'b0, 16, 16, "R4");

      // R5: other command bits kept, request bit cleared
      bus_read(17, v); check("R5", v, mk(4'h2, 4'd0, 16, 1'b0) & ~32'd1);

      // R6: header area write and read, image untouched
      do_write(1'b1, 3, 2, 40, 1);
      do_read(1'b1, 0, 8, "R6");
      do_read(1'b0, 0, 16, "R6");

      // R7: overruns, exact fit, bad code
      do_write(1'b0, 30, 4, 50, 0);
      do_read(1'b0, 28, 4, "R7");
      issue(mk(4'h2, 4'd4, 29, 1'b0), stat(4'h2, 4'd2), "R7");
      do_write(1'b1, 6, 3, 51, 0);
      do_read(1'b1, 0, 8, "R7");
      do_write(1'b0, 28, 4, 52, 1);
      do_read(1'b0, 28, 4, "R7");
      do_write(1'b1, 5, 3, 53, 1);
      do_read(1'b1, 0, 8, "R7");
      issue(mk(4'h7, 4'd0, 0, 1'b0), stat(4'h7, 4'd2), "R7");
      issue(mk(4'h3, 4'd0, 0, 1'b0), stat(4'h3, 4'd2), "R7");

      // R8: authentication fails, then passes once the marker is written
      issue(mk(4'h1, 4'd0, 0, 1'b0), stat(4'h1, 4'd1), "R8");
      bus_write(1, MVAL);
      issue(mk(4'h0, 4'd0, MADR, 1'b0), stat(4'h0, 4'd0), "R8");
      img_m[MADR] = MVAL;
      issue(mk(4'h1, 4'd0, 0, 1'b0), stat(4'h1, 4'd0), "R8");
      check("R9", 32'(pcnt), 32'd0);

      // R9: power-cycle pulses reset_request once
      issue(mk(4'h4, 4'd0, 0, 1'b0), stat(4'h4, 4'd0), "R9");
      repeat (3) @(negedge clk);
      check("R9", 32'(pcnt), 32'd1);

      // R10: a command write during a busy read is dropped
      p0 = pcnt;
      c0 = mk(4'h2, 4'd0, 0, 1'b0);
      bus_write(17, c0);
      bus_write(17, mk(4'h4, 4'd0, 0, 1'b0));
      bus_read(17, v); check("R10", v, c0);
      wait_done();
      bus_read(18, v); check("R10", v, stat(4'h2, 4'd0));
      bus_read(17, v); check("R10", v, c0 & ~32'd1);
      repeat (3) @(negedge clk);
      check("R10", 32'(pcnt), 32'(p0));
      do_read(1'b0, 0, 16, "R10");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule